// File: doc/BRIEF.md
# Single-wire ROM command selector

This block is the identity and addressing layer of a slave device that shares a single open-drain data wire with other slaves and one master. A physical-layer block beneath it turns line activity into three kinds of one-cycle event: the end of a reset/presence exchange, a bit written by the master, and the start of a read time slot in which the slave may pull the line low. The selector tells that block which bit to present in each read slot. A value of 1 means the line is released. Because every slave drives the wire open-drain, the bits of several slaves combine as a wired-AND.

The slave carries a fixed 64-bit identity taken from parameters. The identity has an 8-bit family code, a 48-bit serial number and an 8-bit check byte. After each reset the selector receives an 8-bit command and acts on it. It can send its identity, compare the identity against one the master supplies, skip addressing, or take part in the bitwise search by which the master enumerates all slaves on the wire. When the command completes successfully, the selector raises an enable to the memory-function layer above it. When the command fails, the selector falls silent until the next reset.

Top module: `rom_sel_top`

## Requirements
- R1: A reset event (`rst_evt`) lowers `mem_en` and starts reception of a new command. It also discards any bit or read-slot event that arrives in the same cycle.
- R2: The command is the first 8 master-written bits after a reset event, least significant bit first. The codes are 33h (read), 55h (match), CCh (skip) and F0h (search).
- R3: After 33h the slave sends its 64 identity bits, one per read slot. Index 0 is bit 0 of the family code, bits 8 to 55 are the serial number LSB first, and bits 56 to 63 are the check byte. `mem_en` rises after the 64th slot.
- R4: After 55h the slave compares 64 written bits with its identity in the same bit order. If all 64 bits are equal, `mem_en` rises after the 64th bit and not before.
- R5: During match, the first unequal bit leaves the slave idle. Its remaining bits are ignored, `mem_en` stays low and `tx_bit` stays 1 until a reset event.
- R6: After CCh, `mem_en` rises directly after the 8th command bit. It stays high until the next reset event.
- R7: After F0h, each identity bit takes three slots in turn: a read slot returning the bit, a read slot returning its complement, and a written bit from the master. If every written bit equals the identity bit, `mem_en` rises after the 64th written bit.
- R8: During search, a written bit that differs from the slave's own bit makes the slave drop out. Every later read slot returns 1 and `mem_en` stays low until a reset event.
- R9: Any other command code leaves the slave idle. `mem_en` stays low, `tx_bit` is 1, and further bits are ignored until a reset event.
- R10: `tx_bit` is 1 (line released) whenever the slave is not sending an identity bit or complement. This includes command reception, memory-enabled state and idle.
- R11: After `rst_n` is released, the slave is idle with `mem_en` low and `tx_bit` 1. It ignores written bits until the first reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_evt | input | 1 | One-cycle pulse: reset/presence exchange finished |
| bit_valid | input | 1 | One-cycle pulse: master wrote the bit on `bit_in` |
| bit_in | input | 1 | Value of the written bit |
| rd_slot | input | 1 | One-cycle pulse: a read slot starts and `tx_bit` is taken |
| tx_bit | output | 1 | Bit for the current read slot; 0 pulls the line low, 1 releases it |
| mem_en | output | 1 | Memory-function layer enabled |

## Verification
A reset event can arrive in the same cycle as a written bit or a read slot, and the reset must win. The bench provokes this in two places. First, it raises `rst_evt` together with a written 1 partway through a command, then sends CCh. A bit that slipped into the command shifter would shift the byte and keep `mem_en` low. Second, it raises `rst_evt` together with a read slot in the middle of an identity read, then issues 33h again and expects identity bit 0 in the first slot.

// File: rtl/rom_sel_pkg.sv
package rom_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SEARCH,
        ST_MEM
    } sel_st_e;

    typedef enum logic [1:0] {
        PH_BIT,
        PH_CMP,
        PH_DIR
    } srch_ph_e;

    localparam logic [7:0] CODE_READ   = 8'h33;
    localparam logic [7:0] CODE_MATCH  = 8'h55;
    localparam logic [7:0] CODE_SKIP   = 8'hCC;
    localparam logic [7:0] CODE_SEARCH = 8'hF0;

endpackage

// File: rtl/rom_sel_cmd_rx.sv
module rom_sel_cmd_rx #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic             at_last,
    output logic [CMD_W-1:0] code
);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

    typedef struct packed {
        logic [CMD_W-2:0] sh;
        logic [CNT_W-1:0] cnt;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.cnt = '0;
        end else if (shift_en) begin
            d.sh  = {bit_in, q.sh[CMD_W-2:1]};
            d.cnt = (q.cnt == LAST) ? '0 : q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign at_last = (q.cnt == LAST);
    assign code    = {bit_in, q.sh};

    p_cnt_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (q.cnt == '0));

endmodule

// File: rtl/rom_sel_id_bit.sv
module rom_sel_id_bit #(
    parameter int ID_W = 64
) (
    input  logic [ID_W-1:0]         id,
    input  logic [$clog2(ID_W)-1:0] idx,
    output logic                    bit_o
);
    logic [ID_W-1:0] hit;

    for (genvar g = 0; g < ID_W; g++) begin : g_hit
        assign hit[g] = (idx == ($clog2(ID_W))'(g)) & id[g];
    end

    assign bit_o = |hit;

endmodule

// File: rtl/rom_sel_top.sv
module rom_sel_top
    import rom_sel_pkg::*;
#(
    parameter int FAM_W = 8,
    parameter int SER_W = 48,
    parameter int CHK_W = 8,
    parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h2C,
    parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h5A3C_0F96_E1B7,
    parameter logic [CHK_W-1:0] CHECK_BYTE  = 8'hD4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_evt,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic rd_slot,
    output logic tx_bit,
    output logic mem_en
);
    localparam int ID_W  = FAM_W + SER_W + CHK_W;
    localparam int IDX_W = $clog2(ID_W);
    localparam int CMD_W = $bits(CODE_READ);
    localparam logic [ID_W-1:0]  IDENT    = {CHECK_BYTE, SERIAL_NUM, FAMILY_CODE};
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);

    typedef struct packed {
        sel_st_e           st;
        srch_ph_e          ph;
        logic [IDX_W-1:0]  idx;
    } sel_t;

    sel_t q, d;

    logic             cmd_shift;
    logic             cmd_at_last;
    logic [CMD_W-1:0] cmd_code;
    logic             id_bit;
    logic             idx_last;

    assign cmd_shift = !rst_evt && bit_valid && (q.st == ST_CMD);
    assign idx_last  = (q.idx == IDX_LAST);

    rom_sel_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rst_evt),
        .shift_en (cmd_shift),
        .bit_in   (bit_in),
        .at_last  (cmd_at_last),
        .code     (cmd_code)
    );

    rom_sel_id_bit #(.ID_W(ID_W)) u_idb (
        .id    (IDENT),
        .idx   (q.idx),
        .bit_o (id_bit)
    );

    always_comb begin
        d = q;
        if (rst_evt) begin
            d.st  = ST_CMD;
            d.ph  = PH_BIT;
            d.idx = '0;
        end else begin
            unique case (q.st)
                ST_CMD: begin
                    if (bit_valid && cmd_at_last) begin
                        unique case (cmd_code)
                            CODE_READ:   d.st = ST_READ;
                            CODE_MATCH:  d.st = ST_MATCH;
                            CODE_SKIP:   d.st = ST_MEM;
                            CODE_SEARCH: d.st = ST_SEARCH;
                            default:     d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_READ: begin
                    if (rd_slot) begin
                        if (idx_last) d.st  = ST_MEM;
                        else          d.idx = q.idx + 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (bit_valid) begin
                        if (bit_in != id_bit) d.st  = ST_IDLE;
                        else if (idx_last)    d.st  = ST_MEM;
                        else                  d.idx = q.idx + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    unique case (q.ph)
                        PH_BIT: if (rd_slot) d.ph = PH_CMP;
                        PH_CMP: if (rd_slot) d.ph = PH_DIR;
                        default: begin
                            if (bit_valid) begin
                                d.ph = PH_BIT;
                                if (bit_in != id_bit) d.st  = ST_IDLE;
                                else if (idx_last)    d.st  = ST_MEM;
                                else                  d.idx = q.idx + 1'b1;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_IDLE;
            q.ph  <= PH_BIT;
            q.idx <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        tx_bit = 1'b1;
        if (q.st == ST_READ) begin
            tx_bit = id_bit;
        end else if (q.st == ST_SEARCH) begin
            if (q.ph == PH_BIT)      tx_bit = id_bit;
            else if (q.ph == PH_CMP) tx_bit = !id_bit;
        end
    end

    assign mem_en = (q.st == ST_MEM);

    p_reset_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> (!mem_en && tx_bit));

    p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !rst_evt) |=> mem_en);

    p_mem_after_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_en) |-> $past(bit_valid || rd_slot));

    p_search_compl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEARCH && q.ph == PH_BIT && rd_slot && !rst_evt)
            |=> (tx_bit == !$past(tx_bit)));

    p_idle_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !rst_evt) |=> (q.st == ST_IDLE && tx_bit));

endmodule

// File: tb/rom_sel_top_test.sv
module rom_sel_top_test;
    localparam logic [7:0]  FAM = 8'h2C;
    localparam logic [47:0] SER = 48'h5A3C_0F96_E1B7;
    localparam logic [7:0]  CHK = 8'hD4;
    localparam logic [63:0] ID  = {CHK, SER, FAM};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_evt = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic rd_slot = 1'b0;
    logic tx_bit;
    logic mem_en;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rom_sel_top #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER), .CHECK_BYTE(CHK)) uut (
        .clk(clk), .rst_n(rst_n), .rst_evt(rst_evt), .bit_valid(bit_valid),
        .bit_in(bit_in), .rd_slot(rd_slot), .tx_bit(tx_bit), .mem_en(mem_en)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_evt = 1'b1;
        @(negedge clk); rst_evt = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0;
    endtask

    task automatic rd_bit(output logic b);
        @(negedge clk); b = tx_bit; rd_slot = 1'b1;
        @(negedge clk); rd_slot = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] c);
        for (int i = 0; i < 8; i++) wr_bit(c[i]);
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic b, c2;
        logic [63:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 mem_en after rst_n", 64'(mem_en), 64'd0);
        chk("R11 tx_bit after rst_n", 64'(tx_bit), 64'd1);
        send_byte(8'hCC);
        chk("R11 bits before first reset ignored", 64'(mem_en), 64'd0);
        rd_bit(b);
        chk("R11 released before first reset", 64'(b), 64'd1);

        // R2 R6 R9: sweep every command code
        for (int c = 0; c < 256; c++) begin
            do_reset();
            chk("R1 mem_en low after reset", 64'(mem_en), 64'd0);
            chk("R10 released during command", 64'(tx_bit), 64'd1);
            send_byte(8'(c));
            chk("R6 R9 mem_en after code", 64'(mem_en), 64'(c == 8'hCC));
            rd_bit(b);
            chk("R2 first slot after code", 64'(b),
                (c == 8'h33 || c == 8'hF0) ? 64'(ID[0]) : 64'd1);
            if (c != 8'h33 && c != 8'h55 && c != 8'hCC && c != 8'hF0) begin
                send_byte(8'hCC);
                chk("R9 unknown code stays idle", 64'(mem_en), 64'd0);
                rd_bit(b);
                chk("R9 unknown code released", 64'(b), 64'd1);
            end
        end

        // R3 read identity
        do_reset();
        send_byte(8'h33);
        got = '0;
        for (int i = 0; i < 64; i++) begin
            if (i == 63) chk("R3 mem_en not before last slot", 64'(mem_en), 64'd0);
            rd_bit(b);
            got[i] = b;
        end
        chk("R3 identity bits", got, ID);
        chk("R3 mem_en after read", 64'(mem_en), 64'd1);
        wr_bit(1'b0);
        rd_bit(b);
        chk("R10 released in memory state", 64'(b), 64'd1);
        chk("R6 mem_en holds", 64'(mem_en), 64'd1);
        do_reset();
        chk("R1 reset clears mem_en", 64'(mem_en), 64'd0);

        // R4 match success
        do_reset();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) begin
            if (i == 63) chk("R4 mem_en not before last bit", 64'(mem_en), 64'd0);
            wr_bit(ID[i]);
        end
        chk("R4 match accepted", 64'(mem_en), 64'd1);

        // R5 match with each bit flipped
        for (int k = 0; k < 64; k++) begin
            do_reset();
            send_byte(8'h55);
            for (int i = 0; i < 64; i++) wr_bit(i == k ? !ID[i] : ID[i]);
            chk("R5 mismatch rejected", 64'(mem_en), 64'd0);
            rd_bit(b);
            chk("R5 mismatch released", 64'(b), 64'd1);
        end

        // R7 search full path
        do_reset();
        send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            rd_bit(b);
            rd_bit(c2);
            chk("R7 search bit", 64'(b), 64'(ID[i]));
            chk("R7 search complement", 64'(c2), 64'(!ID[i]));
            wr_bit(ID[i]);
        end
        chk("R7 search selected", 64'(mem_en), 64'd1);

        // R8 search loss at several positions
        for (int t = 0; t < 4; t++) begin
            int k;
            k = (t == 0) ? 0 : (t == 1) ? 17 : (t == 2) ? 40 : 63;
            do_reset();
            send_byte(8'hF0);
            for (int i = 0; i < 64; i++) begin
                rd_bit(b);
                rd_bit(c2);
                if (i > k) begin
                    chk("R8 dropped slave releases bit", 64'(b), 64'd1);
                    chk("R8 dropped slave releases complement", 64'(c2), 64'd1);
                end
                wr_bit(i == k ? !ID[i] : ID[i]);
            end
            chk("R8 dropped slave not selected", 64'(mem_en), 64'd0);
        end

        // R1 collision of reset with a written bit
        do_reset();
        wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
        @(negedge clk); rst_evt = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk); rst_evt = 1'b0; bit_valid = 1'b0;
        send_byte(8'hCC);
        chk("R1 reset beats written bit", 64'(mem_en), 64'd1);

        // R1 collision of reset with a read slot
        do_reset();
        send_byte(8'h33);
        for (int i = 0; i < 5; i++) rd_bit(b);
        @(negedge clk); rst_evt = 1'b1; rd_slot = 1'b1;
        @(negedge clk); rst_evt = 1'b0; rd_slot = 1'b0;
        chk("R1 reset beats read slot released", 64'(tx_bit), 64'd1);
        send_byte(8'h33);
        rd_bit(b);
        chk("R1 read restarts at bit 0", 64'(b), 64'(ID[0]));

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule